// File: doc/BRIEF.md
# Multi-Mode 8-bit Timer/Counter with PWM Output

This block is a single-channel 8-bit timer/counter with one compare register, one waveform output pin and two interrupt requests. It can run as a free-running counter, as a counter that clears itself on a compare hit (auto reload), as a frequency generator that toggles its pin on every hit, or as a phase-correct PWM that counts up to 0xFF and back down to 0x00. The counter advances only on a count tick. A tick comes from one of several prescaler strobes, or from a selected edge of an external pin. The pin passes through a synchronizer and an edge detector first.

Software reaches four 8-bit registers over a simple single-cycle write port and a registered read port: control (mode and tick source), counter, compare value, and interrupt flags with their enables. The prescaler divider chain is outside the block. Its taps arrive as single-cycle strobes on `tap_i`.

Top module: `tmr8_unit`

## Requirements
- R1: After reset, every register reads 0x00, the tick source is stopped, and `wave_o`, `irq_ovf` and `irq_cmp` are 0.
- R2: Tick source field ctrl[4:2]: the value 0 or 7 stops the counter so that it holds its value. A value k in 1..4 makes each cycle with `tap_i[k-1]` high advance the counter by one step. Strobes on the other taps have no effect.
- R3: Tick source 6 counts rising edges of `ext_pin` and tick source 5 counts falling edges. Each selected edge produces exactly one count step, and the opposite edge produces none.
- R4: Mode ctrl[1:0]=0 (free-running): each tick adds one, 0xFF wraps to 0x00, and the tick taken at 0xFF sets the overflow flag (IRQ bit 0).
- R5: Modes 1 (clear on compare) and 3 (frequency generator): a tick taken while the counter equals the compare register sets the counter to 0x00 and sets the compare flag (IRQ bit 1). Compare writes take effect at once in these modes.
- R6: In mode 3 every compare hit toggles `wave_o`. In modes 0 and 1, `wave_o` does not change.
- R7: Mode 2 (phase-correct): the counter counts up to 0xFF, continues down to 0x00, then counts up again. The tick taken at 0x00 while counting down sets the overflow flag.
- R8: In mode 2 a compare hit while counting up drives `wave_o` to 0, and a hit while counting down drives it to 1. A compare write goes to a buffer that becomes active on the tick taken at 0xFF. Reading the compare register returns the buffer.
- R9: Writing 1 to IRQ bit 0 or bit 1 clears that flag, and writing 0 leaves it unchanged. If a new event arrives in the same cycle, the flag stays set.
- R10: `irq_ovf` is the overflow flag gated by enable IRQ bit 4. `irq_cmp` is the compare flag gated by enable IRQ bit 5.
- R11: A write to the counter suppresses any compare hit on the next tick: no flag, no pin change and no clear. The hit logic is back in effect from the tick after that.
- R12: Register addresses: 0 control, 1 counter, 2 compare, 3 IRQ. `bus_rdata` shows the register selected by `bus_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tap_i | input | 4 | Prescaler tap strobes, one cycle each |
| ext_pin | input | 1 | External event pin, asynchronous |
| wave_o | output | 1 | Waveform output |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare-match interrupt request |

## Verification
The assertions assume that the prescaler taps are clean single-cycle strobes and that the external pin holds each level for at least three clocks. With those inputs, the edge pulses never merge. The stimulus meets both conditions. Taps are pulsed for one cycle and then released. The pin is held for five cycles between changes. Random compare writes during PWM operation and random tap patterns during free-running counting exercise the buffering and tick selection. Directed cases cover wrap, turnaround, blocked matches and flag clearing.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_CLR  = 2'd1,
    MODE_PWM  = 2'd2,
    MODE_FREQ = 2'd3
  } tmr_mode_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_CMP  = 2'd2;
  localparam logic [1:0] ADDR_IRQ  = 2'd3;

  localparam int BIT_OVF    = 0;
  localparam int BIT_CMP    = 1;
  localparam int BIT_EN_OVF = 4;
  localparam int BIT_EN_CMP = 5;

  localparam logic [2:0] SEL_EXT_FALL = 3'd5;
  localparam logic [2:0] SEL_EXT_RISE = 3'd6;
endpackage

// File: rtl/tmr8_tick.sv
module tmr8_tick import tmr8_pkg::*; #(
  parameter int N_TAPS = 4,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        sel_i,
  input  logic [N_TAPS-1:0] tap_i,
  input  logic              ext_pin_i,
  output logic              tick_o
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], ext_pin_i};
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign rise = sync_q[SYNC-1] & ~prev_q;
  assign fall = ~sync_q[SYNC-1] & prev_q;

  always_comb begin
    tick_o = 1'b0;
    for (int i = 0; i < N_TAPS; i++)
      if (sel_i == 3'(i + 1)) tick_o = tap_i[i];
    if (sel_i == SEL_EXT_FALL) tick_o = fall;
    if (sel_i == SEL_EXT_RISE) tick_o = rise;
  end

  // R3: a pin edge yields a single one-cycle pulse
  p_one_rise_r3: assert property (@(posedge clk) disable iff (rst) rise |=> !rise);
  p_one_fall_r3: assert property (@(posedge clk) disable iff (rst) fall |=> !fall);
endmodule

// File: rtl/tmr8_count.sv
module tmr8_count import tmr8_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  tmr_mode_e    mode_i,
  input  logic         cnt_wr_i,
  input  logic         cmp_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cmp_buf_o,
  output logic         match_o,
  output logic         ovf_o,
  output logic         up_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] BOT = '0;

  logic [W-1:0] cnt_q, act_q, buf_q;
  logic         up_q, blk_q;
  logic         at_top, at_bot, hit, pwm;

  assign pwm    = (mode_i == MODE_PWM);
  assign at_top = (cnt_q == TOP);
  assign at_bot = (cnt_q == BOT);
  assign hit    = (cnt_q == act_q) && !blk_q;

  assign match_o   = tick_i && hit;
  assign ovf_o     = tick_i && (pwm ? (!up_q && at_bot) : at_top);
  assign cnt_o     = cnt_q;
  assign cmp_buf_o = buf_q;
  assign up_o      = up_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= '0;
      buf_q <= '0;
      up_q  <= 1'b1;
      blk_q <= 1'b0;
    end else begin
      if (cmp_wr_i) buf_q <= wdata_i;
      if (!pwm) begin
        act_q <= cmp_wr_i ? wdata_i : buf_q;
        up_q  <= 1'b1;
      end
      if (cnt_wr_i) begin
        cnt_q <= wdata_i;
        blk_q <= 1'b1;
      end else if (tick_i) begin
        blk_q <= 1'b0;
        unique case (mode_i)
          MODE_FREE: cnt_q <= cnt_q + 1'b1;
          MODE_CLR, MODE_FREQ: cnt_q <= hit ? BOT : cnt_q + 1'b1;
          MODE_PWM: begin
            if (up_q) begin
              if (at_top) begin
                cnt_q <= TOP - 1'b1;
                up_q  <= 1'b0;
                act_q <= buf_q;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end else begin
              if (at_bot) begin
                cnt_q <= BOT + 1'b1;
                up_q  <= 1'b1;
              end else begin
                cnt_q <= cnt_q - 1'b1;
              end
            end
          end
          default: cnt_q <= cnt_q;
        endcase
      end
    end
  end

  // R2: no tick and no write, counter holds
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !cnt_wr_i) |=> $stable(cnt_q));
  // R4: free-running wrap
  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_FREE && tick_i && at_top && !cnt_wr_i) |=> (cnt_q == BOT));
  // R5: clear on hit
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    ((mode_i == MODE_CLR || mode_i == MODE_FREQ) && match_o && !cnt_wr_i) |=> (cnt_q == BOT));
  // R7: turnaround at top and bottom
  p_turn_top_r7: assert property (@(posedge clk) disable iff (rst)
    (pwm && tick_i && up_q && at_top && !cnt_wr_i) |=> (cnt_q == TOP - 1'b1 && !up_q));
  p_turn_bot_r7: assert property (@(posedge clk) disable iff (rst)
    (pwm && tick_i && !up_q && at_bot && !cnt_wr_i) |=> (cnt_q == BOT + 1'b1 && up_q));
  // R8: active compare only moves at the top tick
  p_buf_r8: assert property (@(posedge clk) disable iff (rst)
    (pwm && !(tick_i && up_q && at_top)) |=> $stable(act_q));
endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave import tmr8_pkg::*; (
  input  logic      clk,
  input  logic      rst,
  input  tmr_mode_e mode_i,
  input  logic      match_i,
  input  logic      up_i,
  output logic      wave_o
);
  logic wave_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q <= 1'b0;
    end else if (match_i) begin
      if (mode_i == MODE_FREQ)     wave_q <= ~wave_q;
      else if (mode_i == MODE_PWM) wave_q <= ~up_i;
    end
  end

  assign wave_o = wave_q;

  // R6: pin quiet outside waveform modes
  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_FREE || mode_i == MODE_CLR) |=> $stable(wave_q));
  // R8: up-count hit clears, down-count hit sets
  p_pwm_up_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_PWM && match_i && up_i) |=> !wave_q);
  p_pwm_dn_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_PWM && match_i && !up_i) |=> wave_q);
endmodule

// File: rtl/tmr8_unit.sv
module tmr8_unit import tmr8_pkg::*; #(
  parameter int W      = 8,
  parameter int N_TAPS = 4,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [N_TAPS-1:0] tap_i,
  input  logic              ext_pin,
  output logic              wave_o,
  output logic              irq_ovf,
  output logic              irq_cmp
);
  tmr_mode_e    mode_q;
  logic [2:0]   sel_q;
  logic         ovf_f, cmp_f, en_ovf, en_cmp;
  logic [W-1:0] rdata_q, irq_rd, ctrl_rd;
  logic [W-1:0] cnt, cmp_buf;
  logic         tick, match_ev, ovf_ev, up;
  logic         wr_ctrl, wr_cnt, wr_cmp, wr_irq;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_cnt  = bus_wr && (bus_addr == ADDR_CNT);
  assign wr_cmp  = bus_wr && (bus_addr == ADDR_CMP);
  assign wr_irq  = bus_wr && (bus_addr == ADDR_IRQ);

  tmr8_tick #(.N_TAPS(N_TAPS), .SYNC(SYNC)) u_tick (
    .clk(clk), .rst(rst), .sel_i(sel_q), .tap_i(tap_i),
    .ext_pin_i(ext_pin), .tick_o(tick)
  );

  tmr8_count #(.W(W)) u_count (
    .clk(clk), .rst(rst), .tick_i(tick), .mode_i(mode_q),
    .cnt_wr_i(wr_cnt), .cmp_wr_i(wr_cmp), .wdata_i(bus_wdata),
    .cnt_o(cnt), .cmp_buf_o(cmp_buf), .match_o(match_ev),
    .ovf_o(ovf_ev), .up_o(up)
  );

  tmr8_wave u_wave (
    .clk(clk), .rst(rst), .mode_i(mode_q), .match_i(match_ev),
    .up_i(up), .wave_o(wave_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_FREE;
      sel_q   <= '0;
      ovf_f   <= 1'b0;
      cmp_f   <= 1'b0;
      en_ovf  <= 1'b0;
      en_cmp  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_ctrl) begin
        mode_q <= tmr_mode_e'(bus_wdata[1:0]);
        sel_q  <= bus_wdata[4:2];
      end
      if (wr_irq) begin
        en_ovf <= bus_wdata[BIT_EN_OVF];
        en_cmp <= bus_wdata[BIT_EN_CMP];
      end
      ovf_f <= ovf_ev   | (ovf_f & ~(wr_irq & bus_wdata[BIT_OVF]));
      cmp_f <= match_ev | (cmp_f & ~(wr_irq & bus_wdata[BIT_CMP]));
      unique case (bus_addr)
        ADDR_CTRL: rdata_q <= ctrl_rd;
        ADDR_CNT:  rdata_q <= cnt;
        ADDR_CMP:  rdata_q <= cmp_buf;
        default:   rdata_q <= irq_rd;
      endcase
    end
  end

  always_comb begin
    ctrl_rd      = '0;
    ctrl_rd[1:0] = mode_q;
    ctrl_rd[4:2] = sel_q;
    irq_rd             = '0;
    irq_rd[BIT_OVF]    = ovf_f;
    irq_rd[BIT_CMP]    = cmp_f;
    irq_rd[BIT_EN_OVF] = en_ovf;
    irq_rd[BIT_EN_CMP] = en_cmp;
  end

  assign bus_rdata = rdata_q;
  assign irq_ovf   = ovf_f & en_ovf;
  assign irq_cmp   = cmp_f & en_cmp;

  // R9: clear-by-one without a new event leaves the flag low
  p_ovf_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_irq && bus_wdata[BIT_OVF] && !ovf_ev) |=> !ovf_f);
  p_cmp_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_irq && bus_wdata[BIT_CMP] && !match_ev) |=> !cmp_f);
  // R4/R7: an overflow event always lands in the flag
  p_ovf_set_r4: assert property (@(posedge clk) disable iff (rst) ovf_ev |=> ovf_f);
  // R5: a match event always lands in the flag
  p_cmp_set_r5: assert property (@(posedge clk) disable iff (rst) match_ev |=> cmp_f);
endmodule

// File: tb/sim_tmr8_unit.sv
module sim_tmr8_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [3:0] tap_i = 4'd0;
  logic       ext_pin = 1'b0;
  logic       wave_o, irq_ovf, irq_cmp;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  // PWM reference state
  logic [7:0] m_cnt, m_act, m_buf;
  logic       m_up, m_blk, m_out, m_ovf, m_cmp;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr8_unit u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tap_i(tap_i),
    .ext_pin(ext_pin), .wave_o(wave_o), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic strobe(input logic [3:0] t);
    @(negedge clk); tap_i = t;
    @(negedge clk); tap_i = 4'd0;
  endtask

  task automatic pin(input logic v);
    @(negedge clk); ext_pin = v;
    repeat (5) @(negedge clk);
  endtask

  // Free-running next count from R4
  function automatic logic [7:0] free_next(input logic [7:0] c);
    return c + 8'd1;
  endfunction

  // Phase-correct tick model from R7, R8, R11
  task automatic pwm_tick();
    if (m_cnt == m_act && !m_blk) begin
      m_out = m_up ? 1'b0 : 1'b1;
      m_cmp = 1'b1;
    end
    m_blk = 1'b0;
    if (m_up) begin
      if (m_cnt == 8'hFF) begin m_cnt = 8'hFE; m_up = 1'b0; m_act = m_buf; end
      else m_cnt = m_cnt + 8'd1;
    end else begin
      if (m_cnt == 8'h00) begin m_cnt = 8'h01; m_up = 1'b1; m_ovf = 1'b1; end
      else m_cnt = m_cnt - 8'd1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, exp_c, v;
    logic       w;
    int         sel;
    void'($urandom(32'h1d2c3b4a));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(ADDR_CTRL_T(), d); chk("R1 ctrl", d, 0);
    rd(2'd1, d); chk("R1 count", d, 0);
    rd(2'd2, d); chk("R1 compare", d, 0);
    rd(2'd3, d); chk("R1 irq", d, 0);
    chk("R1 wave", wave_o, 0);
    chk("R1 irq pins", {irq_ovf, irq_cmp}, 0);

    // R12 register access
    wr(2'd2, 8'h5A); rd(2'd2, d); chk("R12 compare readback", d, 8'h5A);
    wr(2'd0, 8'h05); rd(2'd0, d); chk("R12 ctrl readback", d, 8'h05);

    // R2 stopped source ignores taps, selected tap counts
    wr(2'd0, 8'h00); strobe(4'hF); strobe(4'hF);
    rd(2'd1, d); chk("R2 stopped holds", d, 0);
    wr(2'd0, 8'h04); strobe(4'h1); strobe(4'h1); strobe(4'h1); strobe(4'h2); strobe(4'hE);
    rd(2'd1, d); chk("R2 tap0 counts only its own strobes", d, 3);
    wr(2'd0, 8'h1C); strobe(4'hF);
    rd(2'd1, d); chk("R2 source 7 holds", d, 3);

    // R4 wrap and overflow flag
    wr(2'd0, 8'h04); wr(2'd1, 8'hFD);
    strobe(4'h1); strobe(4'h1); strobe(4'h1);
    rd(2'd1, d); chk("R4 wrap count", d, 0);
    rd(2'd3, d); chk("R4 overflow flag", d, 8'h01);

    // R9 write-one-to-clear
    wr(2'd3, 8'h00); rd(2'd3, d); chk("R9 zero write keeps flag", d, 8'h01);
    wr(2'd3, 8'h01); rd(2'd3, d); chk("R9 one write clears flag", d, 8'h00);

    // R10 gating
    wr(2'd1, 8'hFF); strobe(4'h1);
    chk("R10 masked overflow pin", irq_ovf, 0);
    wr(2'd3, 8'h10);
    chk("R10 enabled overflow pin", irq_ovf, 1);
    chk("R10 compare pin stays low", irq_cmp, 0);
    wr(2'd3, 8'h01);
    chk("R10 pin drops after clear", irq_ovf, 0);

    // R5 clear on compare, R6 quiet pin
    w = wave_o;
    wr(2'd0, 8'h05); wr(2'd2, 8'h03); wr(2'd1, 8'h00);
    repeat (4) strobe(4'h1);
    rd(2'd1, d); chk("R5 reload to zero", d, 0);
    rd(2'd3, d); chk("R5 compare flag", d, 8'h02);
    chk("R6 mode 1 pin unchanged", wave_o, w);

    // R6 frequency generator toggles
    wr(2'd3, 8'h03); wr(2'd0, 8'h07); wr(2'd1, 8'h00);
    repeat (4) strobe(4'h1);
    chk("R6 first toggle", wave_o, !w);
    repeat (4) strobe(4'h1);
    chk("R6 second toggle", wave_o, w);

    // R11 counter write blocks the next hit only
    wr(2'd3, 8'h03); wr(2'd1, 8'h03); strobe(4'h1);
    rd(2'd1, d); chk("R11 blocked hit advances", d, 4);
    chk("R11 blocked hit pin", wave_o, w);
    rd(2'd3, d); chk("R11 blocked hit flag", d, 0);
    wr(2'd1, 8'h02); strobe(4'h1); strobe(4'h1);
    rd(2'd1, d); chk("R11 later hit clears", d, 0);
    chk("R11 later hit toggles", wave_o, !w);

    // R3 external edges
    wr(2'd0, 8'h18); wr(2'd1, 8'h00);
    for (int i = 0; i < 3; i++) begin pin(1'b1); pin(1'b0); end
    rd(2'd1, d); chk("R3 rising edges", d, 3);
    wr(2'd0, 8'h14);
    for (int i = 0; i < 4; i++) begin pin(1'b1); pin(1'b0); end
    rd(2'd1, d); chk("R3 falling edges", d, 7);

    // R2/R4 random taps in free-running mode
    wr(2'd3, 8'h03);
    sel = int'($urandom_range(1, 4));
    wr(2'd0, 8'(sel << 2));
    exp_c = 8'($urandom); wr(2'd1, exp_c);
    w = 1'b0;
    for (int i = 0; i < 300; i++) begin
      v = 8'($urandom);
      strobe(v[3:0]);
      if (v[sel-1]) begin
        if (exp_c == 8'hFF) w = 1'b1;
        exp_c = free_next(exp_c);
      end
    end
    rd(2'd1, d); chk("R2 random tap count", d, exp_c);
    rd(2'd3, d); chk("R4 random overflow flag", d[0], w);

    // R7/R8 phase-correct with random compare updates
    wr(2'd0, 8'h04); wr(2'd2, 8'h80); wr(2'd3, 8'h03);
    wr(2'd0, 8'h06); wr(2'd1, 8'h00);
    m_cnt = 8'h00; m_act = 8'h80; m_buf = 8'h80; m_up = 1'b1; m_blk = 1'b1;
    m_out = wave_o; m_ovf = 1'b0; m_cmp = 1'b0;
    for (int i = 0; i < 1200; i++) begin
      if ($urandom_range(0, 39) == 0) begin
        v = 8'($urandom);
        if ($urandom_range(0, 3) == 0) v = 8'hFF;
        if ($urandom_range(0, 3) == 0) v = 8'h00;
        wr(2'd2, v); m_buf = v;
      end
      strobe(4'h1); pwm_tick();
      chk("R8 pwm pin", wave_o, m_out);
    end
    rd(2'd1, d); chk("R7 pwm count", d, m_cnt);
    rd(2'd2, d); chk("R8 compare reads buffer", d, m_buf);
    rd(2'd3, d); chk("R7 pwm flags", d[1:0], {m_cmp, m_ovf});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  function automatic logic [1:0] ADDR_CTRL_T();
    return 2'd0;
  endfunction
endmodule